// File: doc/BRIEF.md
# SDRAM Command and Bank-State Decoder

This block sits on the command side of a synchronous DRAM model or controller front end. On every rising clock edge it samples chip select, the three strobe lines and the address bus, and turns what it sees into exactly one registered, single-cycle command pulse: activate, read, write, precharge, refresh, mode-register set or no-operation. Next to the pulses it presents the row address of the last accepted activate and the column address of the last accepted read or write. It also presents the bank a command addressed and whether auto-precharge was requested.

For each bank the block keeps an open/closed bit. Activate opens a bank. A precharge closes one bank or all of them, depending on the auto-precharge address bit. A read or write that asks for auto-precharge closes its bank in the same cycle the command is reported. Commands that break the bank discipline do not execute and raise an error pulse: a read or write to a closed bank, or an activate to a bank that is already open. While clock enable is sampled low, the block stands frozen. It decodes nothing and holds all of its state.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While reset is asserted, every pulse output, both error pulses, `frozen`, `auto_pre`, `row_addr`, `col_addr`, `bank_sel` and every `bank_open` bit are 0.
- R2: With `cke` high and `cs_n` low at a rising edge, the code {ras_n,cas_n,we_n} selects the command: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set, 111 no-operation. The matching pulse is high for the one cycle after that edge, and at most one pulse is ever high.
- R3: `cs_n` high at an edge produces no pulse and no error, and leaves the addresses, `bank_sel` and `bank_open` unchanged. So does the selected code 110.
- R4: An activate to a closed bank sets `bank_open[b]` for b = addr[11], loads `row_addr` from addr[10:0] and sets `bank_sel` to b.
- R5: A read or write to an open bank pulses `cmd_rd`/`cmd_wr`, loads `col_addr` from addr[9:0] and sets `bank_sel` to addr[11]. `auto_pre` is high in the same cycle exactly when addr[10] was high.
- R6: A read or write to an open bank with addr[10] high clears that bank's `bank_open` bit in the same cycle its pulse is high. The other bank is not affected.
- R7: A precharge pulses `cmd_pre` and sets `bank_sel` to addr[11]. With addr[10] high it clears every `bank_open` bit. With addr[10] low it clears only bank addr[11].
- R8: A read or write to a closed bank pulses `err_closed` and produces no `cmd_rd`/`cmd_wr`. It leaves `col_addr`, `bank_sel`, `auto_pre` low and `bank_open` unchanged.
- R9: An activate to an open bank pulses `err_reopen` and produces no `cmd_act`. It leaves `row_addr`, `bank_sel` and `bank_open` unchanged.
- R10: `cke` low at an edge makes `frozen` 1 for the next cycle. In that cycle there is no pulse and no error, and addresses and bank state hold. The first edge with `cke` high clears `frozen` and decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, low freezes the decoder |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| addr | input | ROW_W+BANK_W (12) | Row/column/auto-precharge bits, bank select on top |
| cmd_act | output | 1 | Activate accepted |
| cmd_rd | output | 1 | Read accepted |
| cmd_wr | output | 1 | Write accepted |
| cmd_pre | output | 1 | Precharge accepted |
| cmd_ref | output | 1 | Refresh accepted |
| cmd_mrs | output | 1 | Mode-register set accepted |
| cmd_nop | output | 1 | Selected no-operation |
| row_addr | output | ROW_W (11) | Row of last accepted activate |
| col_addr | output | COL_W (10) | Column of last accepted read/write |
| auto_pre | output | 1 | Current read/write requested auto-precharge |
| bank_sel | output | BANK_W (1) | Bank of last accepted bank command |
| bank_open | output | NUM_BANKS (2) | Per-bank open flag |
| err_closed | output | 1 | Read/write to a closed bank rejected |
| err_reopen | output | 1 | Activate to an open bank rejected |
| frozen | output | 1 | Clock enable was low at the last edge |

## Verification
The bench uses the default parameters: an 11-bit row field, a 10-bit column field and two banks, so the bank select is the single top address bit and the auto-precharge bit is addr[10]. With only two banks, random traffic repeatedly reaches every pairing of bank state with command. This covers re-activating an open bank, auto-precharge closing one bank while the other stays open, and precharge-all with either bank select value. Directed sequences place freeze cycles and deselected cycles directly before commands, so that they appear before the held state is used again.

// File: rtl/sdcd_pkg.sv
package sdcd_pkg;

    // Strobe code {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CODE_MRS   = 3'b000,
        CODE_REF   = 3'b001,
        CODE_PRE   = 3'b010,
        CODE_ACT   = 3'b011,
        CODE_WR    = 3'b100,
        CODE_RD    = 3'b101,
        CODE_SPARE = 3'b110,
        CODE_NOP   = 3'b111
    } strobe_code_e;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic refr;
        logic mrs;
        logic nop;
    } cmd_req_t;

    localparam cmd_req_t CMD_NONE = '0;

endpackage

// File: rtl/sdcd_strobe_decode.sv
module sdcd_strobe_decode
    import sdcd_pkg::*;
(
    input  logic     en_i,
    input  logic     ras_n_i,
    input  logic     cas_n_i,
    input  logic     we_n_i,
    output cmd_req_t req_o
);

    strobe_code_e code;

    always_comb begin
        code  = strobe_code_e'({ras_n_i, cas_n_i, we_n_i});
        req_o = CMD_NONE;
        if (en_i) begin
            unique case (code)
                CODE_ACT:   req_o.act  = 1'b1;
                CODE_RD:    req_o.rd   = 1'b1;
                CODE_WR:    req_o.wr   = 1'b1;
                CODE_PRE:   req_o.pre  = 1'b1;
                CODE_REF:   req_o.refr = 1'b1;
                CODE_MRS:   req_o.mrs  = 1'b1;
                CODE_NOP:   req_o.nop  = 1'b1;
                CODE_SPARE: req_o      = CMD_NONE;
                default:    req_o      = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sdcd_addr_fields.sv
module sdcd_addr_fields #(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 10,
    parameter int BANK_W = 1,
    localparam int ADDR_W = ROW_W + BANK_W,
    localparam int AP_BIT = ROW_W - 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              ap_o,
    output logic [BANK_W-1:0] bank_o
);

    always_comb begin
        row_o  = addr_i[ROW_W-1:0];
        col_o  = addr_i[COL_W-1:0];
        ap_o   = addr_i[AP_BIT];
        bank_o = addr_i[ADDR_W-1 -: BANK_W];
    end

endmodule

// File: rtl/sdcd_bank_track.sv
module sdcd_bank_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic open_o
);

    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (clr_i) open_d = 1'b0;
        if (set_i) open_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
    end

    assign open_o = open_q;

    AST_SET_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> open_q); // R4

    AST_CLR_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !open_q); // R7

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_i && clr_i)); // R6

endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
    import sdcd_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 10,
    parameter int NUM_BANKS = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ADDR_W   = ROW_W + BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 cmd_act,
    output logic                 cmd_rd,
    output logic                 cmd_wr,
    output logic                 cmd_pre,
    output logic                 cmd_ref,
    output logic                 cmd_mrs,
    output logic                 cmd_nop,
    output logic [ROW_W-1:0]     row_addr,
    output logic [COL_W-1:0]     col_addr,
    output logic                 auto_pre,
    output logic [BANK_W-1:0]    bank_sel,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 err_closed,
    output logic                 err_reopen,
    output logic                 frozen
);

    typedef struct packed {
        cmd_req_t          pulse;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic [BANK_W-1:0] bank;
        logic              err_closed;
        logic              err_reopen;
        logic              frozen;
    } out_state_t;

    out_state_t st_d, st_q;

    cmd_req_t          req;
    logic [ROW_W-1:0]  f_row;
    logic [COL_W-1:0]  f_col;
    logic              f_ap;
    logic [BANK_W-1:0] f_bank;
    logic [NUM_BANKS-1:0] open_q;
    logic [NUM_BANKS-1:0] set_bank;
    logic [NUM_BANKS-1:0] clr_bank;
    logic tgt_open;
    logic act_go, act_bad, rw_req, rw_go, rw_bad;

    sdcd_strobe_decode u_decode (
        .en_i    (cke && !cs_n),
        .ras_n_i (ras_n),
        .cas_n_i (cas_n),
        .we_n_i  (we_n),
        .req_o   (req)
    );

    sdcd_addr_fields #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .BANK_W (BANK_W)
    ) u_fields (
        .addr_i (addr),
        .row_o  (f_row),
        .col_o  (f_col),
        .ap_o   (f_ap),
        .bank_o (f_bank)
    );

    // Bank discipline checks against the current open flags
    always_comb begin
        tgt_open = open_q[f_bank];
        act_go   = req.act && !tgt_open;
        act_bad  = req.act &&  tgt_open;
        rw_req   = req.rd || req.wr;
        rw_go    = rw_req &&  tgt_open;
        rw_bad   = rw_req && !tgt_open;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit         = (f_bank == BANK_W'(b));
        assign set_bank[b] = act_go && hit;
        assign clr_bank[b] = (req.pre && (f_ap || hit)) || (rw_go && f_ap && hit);

        sdcd_bank_track u_track (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_bank[b]),
            .clr_i  (clr_bank[b]),
            .open_o (open_q[b])
        );
    end

    always_comb begin
        st_d            = st_q;
        st_d.pulse      = CMD_NONE;
        st_d.ap         = 1'b0;
        st_d.err_closed = 1'b0;
        st_d.err_reopen = 1'b0;
        st_d.frozen     = !cke;
        if (cke) begin
            st_d.pulse.act  = act_go;
            st_d.pulse.rd   = req.rd && rw_go;
            st_d.pulse.wr   = req.wr && rw_go;
            st_d.pulse.pre  = req.pre;
            st_d.pulse.refr = req.refr;
            st_d.pulse.mrs  = req.mrs;
            st_d.pulse.nop  = req.nop;
            st_d.err_closed = rw_bad;
            st_d.err_reopen = act_bad;
            if (act_go) begin
                st_d.row  = f_row;
                st_d.bank = f_bank;
            end
            if (rw_go) begin
                st_d.col  = f_col;
                st_d.ap   = f_ap;
                st_d.bank = f_bank;
            end
            if (req.pre) begin
                st_d.bank = f_bank;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_act    = st_q.pulse.act;
    assign cmd_rd     = st_q.pulse.rd;
    assign cmd_wr     = st_q.pulse.wr;
    assign cmd_pre    = st_q.pulse.pre;
    assign cmd_ref    = st_q.pulse.refr;
    assign cmd_mrs    = st_q.pulse.mrs;
    assign cmd_nop    = st_q.pulse.nop;
    assign row_addr   = st_q.row;
    assign col_addr   = st_q.col;
    assign auto_pre   = st_q.ap;
    assign bank_sel   = st_q.bank;
    assign bank_open  = open_q;
    assign err_closed = st_q.err_closed;
    assign err_reopen = st_q.err_reopen;
    assign frozen     = st_q.frozen;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_nop})); // R2

    AST_RW_OPEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_rd || cmd_wr) && !auto_pre) |-> bank_open[bank_sel]); // R5

    AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_rd || cmd_wr) && auto_pre) |-> !bank_open[bank_sel]); // R6

    AST_CLOSED_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        err_closed |-> !(cmd_rd || cmd_wr || auto_pre)); // R8

    AST_REOPEN_HOLDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        err_reopen |-> (!cmd_act && $stable(row_addr))); // R9

    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !(cmd_act || cmd_rd || cmd_wr || cmd_pre || cmd_ref || cmd_mrs
                     || cmd_nop || err_closed || err_reopen)); // R10

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> ($stable(bank_open) && $stable(row_addr) && $stable(col_addr))); // R10

endmodule

// File: tb/tb_sdram_cmd_decoder.sv
module tb_sdram_cmd_decoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_nop;
    logic [10:0] row_addr;
    logic [9:0]  col_addr;
    logic auto_pre;
    logic [0:0] bank_sel;
    logic [1:0] bank_open;
    logic err_closed, err_reopen, frozen;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // reference model state
    int m_pulse;   // 0 none,1 act,2 rd,3 wr,4 pre,5 ref,6 mrs,7 nop
    int m_row, m_col, m_bank, m_ap, m_ec, m_er, m_frz;
    bit m_open [2];

    always #5 clk = ~clk;

    sdram_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr),
        .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
        .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs), .cmd_nop(cmd_nop),
        .row_addr(row_addr), .col_addr(col_addr), .auto_pre(auto_pre),
        .bank_sel(bank_sel), .bank_open(bank_open), .err_closed(err_closed),
        .err_reopen(err_reopen), .frozen(frozen)
    );

    task automatic chk(string field, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, field, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("act", cmd_act, m_pulse == 1);
        chk("rd",  cmd_rd,  m_pulse == 2);
        chk("wr",  cmd_wr,  m_pulse == 3);
        chk("pre", cmd_pre, m_pulse == 4);
        chk("ref", cmd_ref, m_pulse == 5);
        chk("mrs", cmd_mrs, m_pulse == 6);
        chk("nop", cmd_nop, m_pulse == 7);
        chk("row_addr", row_addr, m_row);
        chk("col_addr", col_addr, m_col);
        chk("auto_pre", auto_pre, m_ap);
        chk("bank_sel", bank_sel, m_bank);
        chk("bank_open0", bank_open[0], m_open[0]);
        chk("bank_open1", bank_open[1], m_open[1]);
        chk("err_closed", err_closed, m_ec);
        chk("err_reopen", err_reopen, m_er);
        chk("frozen", frozen, m_frz);
    endtask

    // Predicts the outputs after the coming edge from the applied inputs
    task automatic predict();
        int b, a10;
        b   = addr[11];
        a10 = addr[10];
        m_pulse = 0; m_ap = 0; m_ec = 0; m_er = 0;
        m_frz = !cke;
        if (cke && !cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011: if (m_open[b]) m_er = 1;
                        else begin m_open[b] = 1; m_row = addr[10:0]; m_bank = b; m_pulse = 1; end
                3'b101, 3'b100:
                        if (!m_open[b]) m_ec = 1;
                        else begin
                            m_pulse = (we_n) ? 2 : 3;
                            m_col = addr[9:0]; m_bank = b; m_ap = a10;
                            if (a10) m_open[b] = 0;
                        end
                3'b010: begin
                            m_pulse = 4; m_bank = b;
                            if (a10) begin m_open[0] = 0; m_open[1] = 0; end
                            else m_open[b] = 0;
                        end
                3'b001: m_pulse = 5;
                3'b000: m_pulse = 6;
                3'b111: m_pulse = 7;
                default: m_pulse = 0;
            endcase
        end
    endtask

    task automatic step(bit k, bit cs, bit [2:0] code, bit [11:0] a);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = code; addr = a;
        predict();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        m_pulse = 0; m_row = 0; m_col = 0; m_bank = 0; m_ap = 0;
        m_ec = 0; m_er = 0; m_frz = 0; m_open[0] = 0; m_open[1] = 0;
        // R1: reset state while reset held, with a command presented
        cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b011;
        repeat (3) @(negedge clk);
        phase = "R1";
        compare_all();
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
        rst_n = 1'b1;

        phase = "R2";
        step(1, 0, 3'b111, 12'h000);
        step(1, 0, 3'b001, 12'h000);
        step(1, 0, 3'b000, 12'h233);

        phase = "R8";                       // both banks closed
        step(1, 0, 3'b101, {1'b0, 1'b0, 10'h011});
        step(1, 0, 3'b100, {1'b1, 1'b1, 10'h022});

        phase = "R4";
        step(1, 0, 3'b011, {1'b0, 11'h5A5});
        step(1, 0, 3'b011, {1'b1, 11'h123});

        phase = "R9";
        step(1, 0, 3'b011, {1'b0, 11'h7FF});

        phase = "R5";
        step(1, 0, 3'b101, {1'b0, 1'b0, 10'h03F});
        step(1, 0, 3'b100, {1'b1, 1'b0, 10'h2C4});

        phase = "R3";
        step(1, 1, 3'b010, {1'b0, 1'b1, 10'h000});
        step(1, 1, 3'b011, {1'b1, 11'h001});
        step(1, 0, 3'b110, {1'b1, 1'b1, 10'h155});

        phase = "R10";
        step(0, 0, 3'b010, {1'b0, 1'b1, 10'h000});
        step(0, 0, 3'b101, {1'b1, 1'b0, 10'h0AA});
        step(1, 0, 3'b111, 12'h000);

        phase = "R7";
        step(1, 0, 3'b010, {1'b1, 1'b0, 10'h000});
        step(1, 0, 3'b011, {1'b1, 11'h0F0});
        step(1, 0, 3'b010, {1'b0, 1'b1, 10'h000});

        phase = "R6";
        step(1, 0, 3'b011, {1'b0, 11'h00C});
        step(1, 0, 3'b011, {1'b1, 11'h00D});
        step(1, 0, 3'b101, {1'b0, 1'b1, 10'h1F0});
        step(1, 0, 3'b101, {1'b0, 1'b0, 10'h1F1});
        step(1, 0, 3'b100, {1'b1, 1'b1, 10'h0E0});

        phase = "R2";
        for (int i = 0; i < 400; i++) begin
            bit k, cs;
            bit [2:0] code;
            bit [11:0] a;
            k    = ($urandom_range(0, 9) != 0);
            cs   = ($urandom_range(0, 7) == 0);
            code = 3'($urandom_range(0, 7));
            a    = 12'($urandom);
            step(k, cs, code, a);
        end

        summary();
    end

endmodule